// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and a 32K x 8 asynchronous static RAM. The host issues one read or one write at a time through a request/acknowledge handshake. The controller turns each request into the strobe sequence the memory expects: chip select, output gate, write strobe, and a split bidirectional data bus with separate out, in and drive-enable signals. Every memory-side output comes straight from a flip-flop, so the strobes cannot glitch.

The memory's nanosecond limits are fixed tables for two speed grades. The controller converts each limit to a whole number of clock cycles at elaboration time. Each conversion is a ceiling division by the clock-period parameter, and no phase is ever shorter than one cycle. With a 20 ns clock, the fast grade gives a read of 3 cycles and a write of 5 cycles from accept to acknowledge. The slow grade gives a 4-cycle read and a 7-cycle write.

A retention request parks the memory with its chip select inactive so that its supply can be lowered. When the request is withdrawn, chip select stays inactive for a full read-cycle time before any new access is allowed.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever no access is running, ce_n, oe_n and we_n are all 1, the data driver is off, and host_ack and pd_ack are 0.
- R2: A read holds ce_n=0, oe_n=0 and we_n=1 for RD_LEN cycles. RD_LEN is the largest of the rounded-up read-cycle, address-access, chip-access and output-gate-access times (3 cycles for the fast grade at 20 ns). mem_din is sampled as that window closes, and it appears on host_rdata in the single cycle where host_ack=1.
- R3: A write opens with ce_n=0, oe_n=1, we_n=1 and the driver off for TURN_LEN cycles. TURN_LEN is the rounded-up larger of the two output release times (1 cycle for the fast grade).
- R4: we_n then falls while the driver stays off for the rounded-up write-strobe release time (1 cycle for the fast grade), so that the memory's outputs have turned off before any drive.
- R5: The driver then puts the write data on the bus with we_n=0 for WDAT_LEN cycles. WDAT_LEN is large enough to meet data setup, strobe width, chip-low time and write-cycle time (2 cycles for the fast grade).
- R6: we_n then rises for one cycle while ce_n stays 0 and the data is still driven. oe_n is 1 for the whole write, and host_ack=1 in the next cycle with every strobe back to its idle level.
- R7: mem_addr keeps the address latched when the request was accepted, for as long as ce_n=0, even if host_addr changes during the access.
- R8: A request is accepted only in the idle state and only in a cycle where host_ack is 0. Each request yields exactly one single-cycle acknowledge.
- R9: pd_req in the idle state enters retention: ce_n stays 1 and pd_ack=1 from the next cycle. If pd_req and host_req are both high, pd_req wins.
- R10: When pd_req falls, pd_ack drops and ce_n stays 1 for REC_LEN cycles (the rounded-up read-cycle time, 3 cycles for the fast grade). A request that is pending during retention is accepted only after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Access address |
| host_wdata | input | DATA_W | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read data, valid with host_ack |
| pd_req | input | 1 | Retention standby request (level) |
| pd_ack | output | 1 | Memory parked in retention |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output gate, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dout | output | DATA_W | Data toward the memory |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | DATA_W | Data from the memory |

## Verification
The bench targets the edges between phases.

- **Bus turnaround.** A design that drives data in the same cycle the write strobe falls, or while the output gate is still low, shows the driver enable rising early, which means contention on the bus.
- **Read sampling.** A read window one cycle short, or a capture one cycle late, returns either stale data or the value from the wrong cycle.
- **Address changes.** The host address changes in the middle of a write. A design that does not latch the address moves the strobed address while the access is running.
- **Retention.** A request is held pending through retention. Accepting it during recovery shows chip select falling too early.
- **Acknowledge.** The host keeps its request high in the cycle of the acknowledge. Re-accepting it there would show up as a second, unrequested access.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD, ST_WADDR, ST_WHIZ, ST_WDATA, ST_WEND, ST_PD, ST_REC
   } seq_st_t;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic den;
   } pin_ctl_t;

   typedef enum logic [3:0] {
      T_CYC_RD, T_ACC_ADDR, T_ACC_CHIP, T_ACC_GATE, T_REL_CHIP, T_REL_GATE,
      T_REL_WSTB, T_CYC_WR, T_WSTB_MIN, T_CHIP_WMIN, T_DAT_SETUP
   } tparam_e;

   // nanosecond limit for grade 0 (fast) or 1 (slow)
   function automatic int grade_ns(input int grade, input tparam_e t);
      case (t)
         T_CYC_RD, T_ACC_ADDR, T_ACC_CHIP, T_CYC_WR: return (grade != 0) ? 70 : 55;
         T_ACC_GATE:  return (grade != 0) ? 35 : 30;
         T_REL_CHIP:  return (grade != 0) ? 30 : 20;
         T_REL_GATE:  return (grade != 0) ? 25 : 20;
         T_REL_WSTB:  return (grade != 0) ? 30 : 20;
         T_WSTB_MIN:  return (grade != 0) ? 50 : 40;
         T_CHIP_WMIN: return (grade != 0) ? 60 : 50;
         T_DAT_SETUP: return (grade != 0) ? 30 : 25;
         default:     return 1;
      endcase
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // rounded-up cycle count, never below one
   function automatic int ns_to_cyc(input int ns, input int period);
      return max2(1, (ns + period - 1) / period);
   endfunction

   function automatic int grade_cyc(input int grade, input tparam_e t, input int period);
      return ns_to_cyc(grade_ns(grade, t), period);
   endfunction

   function automatic pin_ctl_t ctl_of(input seq_st_t s);
      case (s)
         ST_RD:    return '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, den: 1'b0};
         ST_WADDR: return '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, den: 1'b0};
         ST_WHIZ:  return '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, den: 1'b0};
         ST_WDATA: return '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, den: 1'b1};
         ST_WEND:  return '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, den: 1'b1};
         default:  return '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, den: 1'b0};
      endcase
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("sram_phase_timer: CNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= CNT_W'(1);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q > CNT_W'(1))
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sram_seq.sv
module sram_seq
   import sram_ctrl_pkg::*;
#(
   parameter int RD_LEN   = 3,
   parameter int TURN_LEN = 1,
   parameter int HIZ_LEN  = 1,
   parameter int WDAT_LEN = 2,
   parameter int REC_LEN  = 3
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    req,
   input  logic    wr,
   input  logic    pd_req,
   output seq_st_t st_nxt,
   output logic    accept,
   output logic    rd_done,
   output logic    ack
);
   localparam int MAX_LEN = max2(max2(max2(RD_LEN, TURN_LEN), max2(HIZ_LEN, WDAT_LEN)), REC_LEN);
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   seq_st_t          st_q;
   logic             last;
   logic             wr_done;
   logic             load;
   logic [CNT_W-1:0] len_nxt;

   always_comb begin
      st_nxt  = st_q;
      accept  = 1'b0;
      rd_done = 1'b0;
      wr_done = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (pd_req)
               st_nxt = ST_PD;
            else if (req && !ack) begin
               accept = 1'b1;
               st_nxt = wr ? ST_WADDR : ST_RD;
            end
         end
         ST_RD: if (last) begin
            rd_done = 1'b1;
            st_nxt  = ST_IDLE;
         end
         ST_WADDR: if (last) st_nxt = ST_WHIZ;
         ST_WHIZ:  if (last) st_nxt = ST_WDATA;
         ST_WDATA: if (last) st_nxt = ST_WEND;
         ST_WEND: begin
            wr_done = 1'b1;
            st_nxt  = ST_IDLE;
         end
         ST_PD:  if (!pd_req) st_nxt = ST_REC;
         ST_REC: if (last) st_nxt = ST_IDLE;
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      case (st_nxt)
         ST_RD:    len_nxt = CNT_W'(RD_LEN);
         ST_WADDR: len_nxt = CNT_W'(TURN_LEN);
         ST_WHIZ:  len_nxt = CNT_W'(HIZ_LEN);
         ST_WDATA: len_nxt = CNT_W'(WDAT_LEN);
         ST_REC:   len_nxt = CNT_W'(REC_LEN);
         default:  len_nxt = CNT_W'(1);
      endcase
   end

   assign load = (st_nxt != st_q);

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (len_nxt),
      .last     (last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= ST_IDLE;
         ack  <= 1'b0;
      end else begin
         st_q <= st_nxt;
         ack  <= rd_done | wr_done;
      end
   end
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  seq_st_t           st_nxt,
   input  logic              accept,
   input  logic              rd_done,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic [DATA_W-1:0] mem_din,
   output logic [DATA_W-1:0] rdata,
   output logic              pd_ack,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en
);
   pin_ctl_t ctl_nxt;

   assign ctl_nxt = ctl_of(st_nxt);

   always_ff @(posedge clk) begin
      if (rst) begin
         mem_ce_n    <= 1'b1;
         mem_oe_n    <= 1'b1;
         mem_we_n    <= 1'b1;
         mem_dout_en <= 1'b0;
         pd_ack      <= 1'b0;
         mem_addr    <= '0;
         mem_dout    <= '0;
         rdata       <= '0;
      end else begin
         mem_ce_n    <= ctl_nxt.ce_n;
         mem_oe_n    <= ctl_nxt.oe_n;
         mem_we_n    <= ctl_nxt.we_n;
         mem_dout_en <= ctl_nxt.den;
         pd_ack      <= (st_nxt == ST_PD);
         if (accept) begin
            mem_addr <= addr_in;
            mem_dout <= wdata_in;
         end
         if (rd_done)
            rdata <= mem_din;
      end
   end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 15,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 20,
   parameter int SPEED_GRADE   = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ack,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              pd_req,
   output logic              pd_ack,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en,
   input  logic [DATA_W-1:0] mem_din
);
   localparam int P = CLK_PERIOD_NS;
   localparam int G = SPEED_GRADE;

   localparam int RD_LEN   = max2(max2(grade_cyc(G, T_CYC_RD, P), grade_cyc(G, T_ACC_ADDR, P)),
                                  max2(grade_cyc(G, T_ACC_CHIP, P), grade_cyc(G, T_ACC_GATE, P)));
   localparam int TURN_LEN = ns_to_cyc(max2(grade_ns(G, T_REL_CHIP), grade_ns(G, T_REL_GATE)), P);
   localparam int HIZ_LEN  = grade_cyc(G, T_REL_WSTB, P);
   localparam int WDAT_LEN = max2(max2(grade_cyc(G, T_DAT_SETUP, P),
                                       grade_cyc(G, T_WSTB_MIN, P) - HIZ_LEN),
                                  max2(max2(grade_cyc(G, T_CHIP_WMIN, P) - HIZ_LEN - TURN_LEN,
                                            grade_cyc(G, T_CYC_WR, P) - TURN_LEN - HIZ_LEN - 1),
                                       1));
   localparam int REC_LEN  = grade_cyc(G, T_CYC_RD, P);

   generate
      if (SPEED_GRADE != 0 && SPEED_GRADE != 1) begin : g_bad_grade
         $error("sram_async_ctrl: SPEED_GRADE must be 0 or 1");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("sram_async_ctrl: CLK_PERIOD_NS must be positive");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
         $error("sram_async_ctrl: bus widths must be positive");
      end
   endgenerate

   seq_st_t st_nxt;
   logic    accept;
   logic    rd_done;

   sram_seq #(
      .RD_LEN   (RD_LEN),
      .TURN_LEN (TURN_LEN),
      .HIZ_LEN  (HIZ_LEN),
      .WDAT_LEN (WDAT_LEN),
      .REC_LEN  (REC_LEN)
   ) u_seq (
      .clk     (clk),
      .rst     (rst),
      .req     (host_req),
      .wr      (host_wr),
      .pd_req  (pd_req),
      .st_nxt  (st_nxt),
      .accept  (accept),
      .rd_done (rd_done),
      .ack     (host_ack)
   );

   sram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .clk         (clk),
      .rst         (rst),
      .st_nxt      (st_nxt),
      .accept      (accept),
      .rd_done     (rd_done),
      .addr_in     (host_addr),
      .wdata_in    (host_wdata),
      .mem_din     (mem_din),
      .rdata       (host_rdata),
      .pd_ack      (pd_ack),
      .mem_addr    (mem_addr),
      .mem_ce_n    (mem_ce_n),
      .mem_oe_n    (mem_oe_n),
      .mem_we_n    (mem_we_n),
      .mem_dout    (mem_dout),
      .mem_dout_en (mem_dout_en)
   );
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
   parameter int ADDR_W = 15
) (
   input logic              clk,
   input logic              rst,
   input logic              host_ack,
   input logic              pd_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dout_en
);
   // R1: a deselected chip never sees a strobe or a driven bus
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      mem_ce_n |-> (mem_we_n && !mem_dout_en));

   // R2: output gate low only in a selected read with the write strobe high
   a_r2_read_strobes: assert property (@(posedge clk) disable iff (rst)
      !mem_oe_n |-> (mem_we_n && !mem_ce_n));

   // R4: the driver is never on in the cycle the write strobe falls
   a_r4_turnaround: assert property (@(posedge clk) disable iff (rst)
      $fell(mem_we_n) |-> !mem_dout_en);

   // R5: the driver switches on only after the strobe has been low a cycle
   a_r5_drive_after_strobe: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_dout_en) |-> (!mem_we_n && $past(!mem_we_n)));

   // R6: output gate high whenever the write strobe or the driver is active
   a_r6_gate_high_in_write: assert property (@(posedge clk) disable iff (rst)
      (!mem_we_n || mem_dout_en) |-> mem_oe_n);

   // R7: the address holds while the chip stays selected
   a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   // R8: the acknowledge lasts a single cycle
   a_r8_ack_pulse: assert property (@(posedge clk) disable iff (rst)
      host_ack |=> !host_ack);

   // R9: retention keeps the chip deselected
   a_r9_retention_deselect: assert property (@(posedge clk) disable iff (rst)
      pd_ack |-> mem_ce_n);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .host_ack    (host_ack),
   .pd_ack      (pd_ack),
   .mem_addr    (mem_addr),
   .mem_ce_n    (mem_ce_n),
   .mem_oe_n    (mem_oe_n),
   .mem_we_n    (mem_we_n),
   .mem_dout_en (mem_dout_en)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;
   localparam int PER = 20;

   // independent cycle counts for the fast grade at 20 ns
   function automatic int up(input int ns);
      int c;
      c = (ns + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
   localparam int RD   = mx(up(55), up(30));
   localparam int TURN = up(20);
   localparam int HIZ  = up(20);
   localparam int WD   = mx(mx(up(25), up(40) - HIZ), mx(up(50) - HIZ - TURN, 1));
   localparam int REC  = up(55);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic host_req = 1'b0, host_wr = 1'b0, pd_req = 1'b0;
   logic [14:0] host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic host_ack, pd_ack, mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
   logic [7:0] host_rdata, mem_dout, mem_din;
   logic [14:0] mem_addr;

   always #10 clk = ~clk;

   sram_async_ctrl i_sram_async_ctrl (
      .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
      .host_rdata(host_rdata), .pd_req(pd_req), .pd_ack(pd_ack),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
      .mem_din(mem_din)
   );

   // behavioural memory
   logic [7:0] sim_mem [int];
   logic [7:0] exp_mem [int];
   function automatic logic [7:0] peek(input logic [14:0] a);
      if (sim_mem.exists(int'(a))) return sim_mem[int'(a)];
      return a[7:0] ^ 8'h5A;
   endfunction
   function automatic logic [7:0] expect_rd(input logic [14:0] a);
      if (exp_mem.exists(int'(a))) return exp_mem[int'(a)];
      return a[7:0] ^ 8'h5A;
   endfunction
   always @(*) mem_din = (!mem_ce_n && !mem_oe_n && mem_we_n) ? peek(mem_addr) : 8'h00;

   // reference model: one expected entry per cycle
   typedef struct {
      logic [5:0]  ctl;   // {ce_n, oe_n, we_n, dout_en, host_ack, pd_ack}
      logic        chk_a;
      logic [14:0] addr;
      logic        chk_d;
      logic [7:0]  dout;
      logic        chk_r;
      logic [7:0]  rd;
      string       tag;
   } exp_t;
   exp_t q[$];

   function automatic exp_t mk(input logic [5:0] c, input string t);
      exp_t e;
      e.ctl = c; e.tag = t;
      e.chk_a = 1'b0; e.addr = '0; e.chk_d = 1'b0; e.dout = '0; e.chk_r = 1'b0; e.rd = '0;
      return e;
   endfunction

   int total = 0, bad = 0, cyc = 0;
   bit done = 0;

   always @(negedge clk) begin
      exp_t e;
      logic [5:0] act;
      if (!done) begin
         cyc++;
         if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL R8 watchdog: actual=%0d cycles expected<=20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
         if (cyc >= 2) begin
            if (q.size() > 0) e = q.pop_front();
            else e = mk(6'b111000, "R1");
            act = {mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en, host_ack, pd_ack};
            total++;
            if (act !== e.ctl || (e.chk_a && mem_addr !== e.addr) ||
                (e.chk_d && mem_dout !== e.dout) || (e.chk_r && host_rdata !== e.rd)) begin
               bad++;
               $display("FAIL %s cycle %0d: actual ctl=%b addr=%h dout=%h rdata=%h expected ctl=%b addr=%h dout=%h rdata=%h",
                        e.tag, cyc, act, mem_addr, mem_dout, host_rdata, e.ctl, e.addr, e.dout, e.rd);
            end
            if (!mem_ce_n && !mem_we_n && mem_dout_en) sim_mem[int'(mem_addr)] = mem_dout;
         end
      end
   end

   task automatic do_wr(input logic [14:0] a, input logic [7:0] d, input bit scramble);
      exp_t e;
      int n;
      @(posedge clk); #1;
      host_req = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
      q.push_back(mk(6'b111000, "R8"));
      for (int i = 0; i < TURN; i++) begin
         e = mk(6'b011000, "R3"); e.chk_a = 1; e.addr = a; q.push_back(e);
      end
      for (int i = 0; i < HIZ; i++) begin
         e = mk(6'b010000, "R4"); e.chk_a = 1; e.addr = a; q.push_back(e);
      end
      for (int i = 0; i < WD; i++) begin
         e = mk(6'b010100, "R5"); e.chk_a = 1; e.addr = a; e.chk_d = 1; e.dout = d; q.push_back(e);
      end
      e = mk(6'b011100, "R6"); e.chk_a = 1; e.addr = a; e.chk_d = 1; e.dout = d; q.push_back(e);
      q.push_back(mk(6'b111010, "R6"));
      exp_mem[int'(a)] = d;
      n = 1 + TURN + HIZ + WD + 2;
      repeat (2) @(posedge clk);
      #1;
      if (scramble) begin  // R7: host inputs move mid-access
         host_addr = ~a; host_wdata = ~d;
      end
      repeat (n - 2) @(posedge clk);
      #1 host_req = 1'b0;
   endtask

   task automatic push_rd(input logic [14:0] a);
      exp_t e;
      for (int i = 0; i < RD; i++) begin
         e = mk(6'b001000, "R2"); e.chk_a = 1; e.addr = a; q.push_back(e);
      end
      e = mk(6'b111010, "R2"); e.chk_r = 1; e.rd = expect_rd(a); q.push_back(e);
   endtask

   task automatic do_rd(input logic [14:0] a);
      @(posedge clk); #1;
      host_req = 1'b1; host_wr = 1'b0; host_addr = a;
      q.push_back(mk(6'b111000, "R8"));
      push_rd(a);
      repeat (RD + 2) @(posedge clk);
      #1 host_req = 1'b0;
   endtask

   // R9/R10: retention with a read pending the whole time
   task automatic do_pd(input int hold, input logic [14:0] a);
      int n;
      @(posedge clk); #1;
      pd_req = 1'b1; host_req = 1'b1; host_wr = 1'b0; host_addr = a;
      q.push_back(mk(6'b111000, "R9"));
      for (int i = 0; i < hold + 1; i++) q.push_back(mk(6'b111001, "R9"));
      for (int i = 0; i < REC; i++) q.push_back(mk(6'b111000, "R10"));
      q.push_back(mk(6'b111000, "R10"));
      push_rd(a);
      n = 1 + (hold + 1) + REC + 1 + RD + 1;
      repeat (1 + hold) @(posedge clk);
      #1 pd_req = 1'b0;
      repeat (n - 1 - hold) @(posedge clk);
      #1 host_req = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      repeat (4) @(posedge clk);               // R1 idle after reset
      do_wr(15'h0000, 8'hA5, 1'b0);
      do_wr(15'h7FFF, 8'h3C, 1'b1);            // top address, R7 scramble
      do_rd(15'h0000);
      do_rd(15'h7FFF);
      do_rd(15'h1234);                         // never written
      do_wr(15'h1234, 8'hFF, 1'b0);
      do_rd(15'h1234);
      do_wr(15'h2AAA, 8'h00, 1'b1);
      do_rd(15'h2AAA);
      do_pd(5, 15'h7FFF);
      do_pd(0, 15'h2AAA);
      do_wr(15'h0001, 8'h96, 1'b0);
      do_rd(15'h0001);
      repeat (4) @(posedge clk);
      #1;
      if (q.size() != 0) begin
         total++; bad++;
         $display("FAIL R8 model queue not drained: actual=%0d expected=0", q.size());
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule